// File: doc/BRIEF.md
# DRAM Controller Performance Counter Bank

This block holds four performance counters that watch a DRAM controller. Slot 0 is a free-running cycle counter. Slots 1 to 3 are event counters. Each event counter picks one strobe out of a vector of event strobes with an 8-bit select code. Software reaches the bank through a plain strobe-style register port. Each slot has a control word and a read-only count word. Reads are combinational. A write lands on the next rising clock edge.

The cycle counter is the master of the bank. Other slots advance only while it is enabled and has not wrapped. When it wraps, the whole bank freezes and the interrupt line rises. The interrupt stays high until software completes the clear handshake of the cycle counter.

The two kinds of counter clear in different ways:
- The cycle counter has a two-state clear machine, `CLR_IDLE` and `CLR_ARMED`.
  - `CLR_IDLE -> CLR_ARMED`: a control write with the clear bit at 0.
  - `CLR_ARMED -> CLR_IDLE`: a control write with the clear bit at 1. This write zeroes the count and drops the overflow.
  - Any other write leaves the state where it is.
- Each event counter has a two-state run machine, `EV_LIVE` and `EV_HELD`.
  - `EV_LIVE -> EV_HELD`: the counter wraps on a counting clock.
  - `EV_HELD -> EV_LIVE`: a control write with the clear bit at 0. This write also zeroes the count. It works from either state.

Example select codes: 0x04 for read accesses, 0x05 for write accesses, 0x20 for read commands, 0x21 for write commands and 0x37 for refresh. Each code is the index of the strobe that the event counter watches.

Top module: `dram_perf_bank`

## Requirements
- R1: Slot n has its control word at byte address 0x00+4n and its count word at 0x20+4n, for n = 0..3. Any other address reads as zero. Count words are zero-extended to 32 bits.
- R2: Control word layout: bit 0 is the overflow flag, bit 1 is the clear bit, bit 2 is the enable bit, bits 31:24 are the select code. All other bits read 0. Writes to bit 0 are ignored. After reset every control word reads 0x00000002.
- R3: The cycle counter adds one on every clock in which its enable is set and it has not overflowed. Its select field always reads 0, whatever was written to it.
- R4: When the cycle counter wraps, its count becomes 0, its overflow flag sets, `irq` rises, and no counter advances until the cycle counter is cleared.
- R5: `irq` equals the cycle-counter overflow flag. It stays high, even across enable writes, until a completed cycle clear drops it.
- R6: The cycle counter clears only through a handshake. A control write with bit 1 = 0 arms it, and bit 1 then reads 0. The next control write with bit 1 = 1 zeroes the count and the overflow flag. A write with bit 1 = 1 that was not armed changes nothing.
- R7: Writing the cycle-counter enable to 0 freezes all four counts, whatever the event strobes do.
- R8: An event counter adds one on each clock in which three things hold: its own enable is set, the bank is running, and the strobe indexed by its select code is high. A select code at or above the strobe vector width counts nothing.
- R9: A control write with bit 1 = 0 to an event slot zeroes its count and its overflow flag on that edge. The clear bit of an event slot always reads 1.
- R10: When an event counter wraps, its count becomes 0 and its overflow flag sets. It stays at 0 until it is cleared. `irq` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_strobe | input | EVT_W | Event strobes from the controller, one per select code |
| irq | output | 1 | High while the cycle counter is in overflow |

## Verification
The hardest state to reach is a wrap. At full width the cycle counter needs more than four billion clocks to wrap, so the bench builds the bank with an 8-bit counter width. It then steps the cycle counter to its all-ones value by timing the clocks between an enable write and a disable write.

An event-counter wrap needs even more care, because the cycle counter would wrap first. The bench lets the event counter reach 200, clears only the cycle counter, and then runs 56 more clocks. The event counter wraps while the cycle counter sits far from its own limit.

// File: rtl/perf_pkg.sv
package perf_pkg;
    localparam int NUM_SLOTS = 4;
    localparam int SEL_W     = 8;
    localparam int OVF_POS   = 0;
    localparam int CLR_POS   = 1;
    localparam int EN_POS    = 2;
    localparam int SEL_LSB   = 24;

    typedef enum logic { CLR_IDLE = 1'b0, CLR_ARMED = 1'b1 } cyc_clr_e;
    typedef enum logic { EV_LIVE = 1'b0, EV_HELD = 1'b1 } ev_run_e;
endpackage

// File: rtl/perf_cycle_unit.sv
module perf_cycle_unit
    import perf_pkg::*;
#(
    parameter int CTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             wr_en_bit,
    input  logic             wr_clr_bit,
    output logic [CTR_W-1:0] cnt_o,
    output logic [31:0]      ctrl_o,
    output logic             run_o,
    output logic             ovf_o
);
    localparam logic [CTR_W-1:0] CNT_MAX = '1;

    cyc_clr_e         clr_st, clr_nx;
    logic             en_q, ovf_q;
    logic [CTR_W-1:0] cnt_q;
    logic             do_clear, running, clr_rb;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) clr_st <= CLR_IDLE;
        else        clr_st <= clr_nx;
    end

    always_comb begin
        clr_nx = clr_st;
        unique case (clr_st)
            CLR_IDLE:  if (ctrl_wr && !wr_clr_bit) clr_nx = CLR_ARMED;
            CLR_ARMED: if (ctrl_wr &&  wr_clr_bit) clr_nx = CLR_IDLE;
        endcase
    end

    // outputs of the clear machine
    always_comb begin
        do_clear = 1'b0;
        clr_rb   = 1'b0;
        unique case (clr_st)
            CLR_IDLE:  clr_rb   = 1'b1;
            CLR_ARMED: do_clear = ctrl_wr && wr_clr_bit;
        endcase
    end

    assign running = en_q && !ovf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            ovf_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            if (ctrl_wr) en_q <= wr_en_bit;
            if (do_clear) begin
                cnt_q <= '0;
                ovf_q <= 1'b0;
            end else if (running) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CNT_MAX) ovf_q <= 1'b1;
            end
        end
    end

    always_comb begin
        ctrl_o          = '0;
        ctrl_o[OVF_POS] = ovf_q;
        ctrl_o[CLR_POS] = clr_rb;
        ctrl_o[EN_POS]  = en_q;
    end

    assign cnt_o = cnt_q;
    assign run_o = running;
    assign ovf_o = ovf_q;

    p_cyc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !do_clear) |=> cnt_q == CTR_W'($past(cnt_q) + 1'b1));
    p_cyc_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !do_clear && cnt_q == CNT_MAX) |=> (ovf_q && cnt_q == '0));
    p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !do_clear) |=> ovf_q);
    p_noarm_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_st == CLR_IDLE && !running) |=> $stable(cnt_q));
endmodule

// File: rtl/perf_event_unit.sv
module perf_event_unit
    import perf_pkg::*;
#(
    parameter int CTR_W = 32,
    parameter int EVT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             wr_en_bit,
    input  logic             wr_clr_bit,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             run_i,
    input  logic [EVT_W-1:0] evt_i,
    output logic [CTR_W-1:0] cnt_o,
    output logic [31:0]      ctrl_o
);
    localparam int               IDX_W   = $clog2(EVT_W);
    localparam logic [CTR_W-1:0] CNT_MAX = '1;

    ev_run_e          st_q, st_nx;
    logic             en_q;
    logic [SEL_W-1:0] sel_q;
    logic [CTR_W-1:0] cnt_q;
    logic             clr_req, sel_hit, hit;

    assign clr_req = ctrl_wr && !wr_clr_bit;
    assign sel_hit = (int'(sel_q) < EVT_W) ? evt_i[sel_q[IDX_W-1:0]] : 1'b0;
    assign hit     = en_q && run_i && sel_hit && (st_q == EV_LIVE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= EV_LIVE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            EV_LIVE: if (!clr_req && hit && cnt_q == CNT_MAX) st_nx = EV_HELD;
            EV_HELD: if (clr_req) st_nx = EV_LIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= '0;
            cnt_q <= '0;
        end else begin
            if (ctrl_wr) begin
                en_q  <= wr_en_bit;
                sel_q <= wr_sel;
            end
            if (clr_req)  cnt_q <= '0;
            else if (hit) cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        ctrl_o                        = '0;
        ctrl_o[OVF_POS]               = (st_q == EV_HELD);
        ctrl_o[CLR_POS]               = 1'b1;
        ctrl_o[EN_POS]                = en_q;
        ctrl_o[SEL_LSB +: SEL_W]      = sel_q;
    end

    assign cnt_o = cnt_q;

    p_ev_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clr_req) |=> $stable(cnt_q));
    p_ev_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (cnt_q == '0 && st_q == EV_LIVE));
    p_ev_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == EV_HELD && !clr_req) |=> (st_q == EV_HELD && $stable(cnt_q)));
endmodule

// File: rtl/perf_regmux.sv
module perf_regmux
    import perf_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [NUM_SLOTS-1:0][31:0]      ctrl_i,
    input  logic [NUM_SLOTS-1:0][31:0]      cnt_i,
    output logic [31:0]                     rdata_o
);
    logic [1:0] slot;
    assign slot = addr_i[3:2];

    always_comb begin
        rdata_o = '0;
        if (addr_i[1:0] == 2'b00) begin
            if (addr_i[ADDR_W-1:4] == '0)
                rdata_o = ctrl_i[slot];
            else if (addr_i[ADDR_W-1:4] == (ADDR_W-4)'(2))
                rdata_o = cnt_i[slot];
        end
    end
endmodule

// File: rtl/dram_perf_bank.sv
module dram_perf_bank
    import perf_pkg::*;
#(
    parameter int CTR_W  = 32,
    parameter int EVT_W  = 64,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [EVT_W-1:0]  evt_strobe,
    output logic              irq
);
    logic [NUM_SLOTS-1:0]        ctrl_wr;
    logic [NUM_SLOTS-1:0][31:0]  ctrl_w;
    logic [NUM_SLOTS-1:0][31:0]  cnt_w;
    logic [CTR_W-1:0]            cyc_cnt;
    logic                        bank_run;
    logic                        cyc_ovf;
    logic                        unused_wbits;

    assign unused_wbits = ^{reg_wdata[SEL_LSB-1:EN_POS+1], reg_wdata[OVF_POS]};

    // control-word write decode
    always_comb begin
        for (int n = 0; n < NUM_SLOTS; n++)
            ctrl_wr[n] = reg_wr && reg_addr[1:0] == 2'b00 &&
                         reg_addr[ADDR_W-1:4] == '0 && int'(reg_addr[3:2]) == n;
    end

    perf_cycle_unit #(.CTR_W(CTR_W)) u_cycle (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr[0]),
        .wr_en_bit  (reg_wdata[EN_POS]),
        .wr_clr_bit (reg_wdata[CLR_POS]),
        .cnt_o      (cyc_cnt),
        .ctrl_o     (ctrl_w[0]),
        .run_o      (bank_run),
        .ovf_o      (cyc_ovf)
    );
    assign cnt_w[0] = 32'(cyc_cnt);

    for (genvar g = 1; g < NUM_SLOTS; g++) begin : g_evt
        logic [CTR_W-1:0] ev_cnt;
        perf_event_unit #(.CTR_W(CTR_W), .EVT_W(EVT_W)) u_evt (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_wr    (ctrl_wr[g]),
            .wr_en_bit  (reg_wdata[EN_POS]),
            .wr_clr_bit (reg_wdata[CLR_POS]),
            .wr_sel     (reg_wdata[SEL_LSB +: SEL_W]),
            .run_i      (bank_run),
            .evt_i      (evt_strobe),
            .cnt_o      (ev_cnt),
            .ctrl_o     (ctrl_w[g])
        );
        assign cnt_w[g] = 32'(ev_cnt);
    end

    perf_regmux #(.ADDR_W(ADDR_W)) u_mux (
        .addr_i  (reg_addr),
        .ctrl_i  (ctrl_w),
        .cnt_i   (cnt_w),
        .rdata_o (reg_rdata)
    );

    assign irq = cyc_ovf;

    p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[1:0] != 2'b00 || reg_addr[3:2] == 2'b00 && 1'b0 ||
         (reg_addr[ADDR_W-1:4] != '0 && reg_addr[ADDR_W-1:4] != (ADDR_W-4)'(2)))
        |-> reg_rdata == 32'h0);
    p_irq_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> $stable(cnt_w[1]) || $past(ctrl_wr[1]));
endmodule

// File: tb/tb_dram_perf_bank.sv
module tb_dram_perf_bank;
    localparam int CW = 8;
    localparam int EW = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [EW-1:0] evt_strobe = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dram_perf_bank #(.CTR_W(CW), .EVT_W(EW), .ADDR_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_strobe(evt_strobe), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic rd_check(string tag, logic [7:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    // lets the cycle counter advance exactly k clocks (k >= 1)
    task automatic run_cycles(int k);
        wr(8'h00, 32'hFF000006);
        repeat (k - 1) @(negedge clk);
        wr(8'h00, 32'hFF000002);
    endtask

    task automatic t_reset;
        for (int n = 0; n < 4; n++) begin
            rd_check("R2 reset ctrl", 8'(4 * n), 32'h2);
            rd_check("R1 reset count", 8'(8'h20 + 4 * n), 32'h0);
        end
        rd_check("R1 unmapped", 8'h14, 32'h0);
        rd_check("R1 misaligned", 8'h21, 32'h0);
        check("R5 reset irq", 32'(irq), 32'h0);
    endtask

    task automatic t_basic;
        wr(8'h04, 32'h04000006);
        wr(8'h08, 32'h05000006);
        wr(8'h0C, 32'h80000006);
        rd_check("R2 ctrl1 readback", 8'h04, 32'h04000006);
        evt_strobe = ~(64'h1 << 5);
        run_cycles(10);
        rd_check("R3 cycle count", 8'h20, 32'd10);
        rd_check("R8 ev1 count", 8'h24, 32'd10);
        rd_check("R8 ev2 strobe low", 8'h28, 32'd0);
        rd_check("R8 ev3 out of range", 8'h2C, 32'd0);
        rd_check("R3 cycle select reads 0", 8'h00, 32'h2);
        evt_strobe = '1;
        repeat (5) @(negedge clk);
        rd_check("R7 freeze cycle", 8'h20, 32'd10);
        rd_check("R7 freeze ev1", 8'h24, 32'd10);
        evt_strobe = 64'h20;
        run_cycles(3);
        rd_check("R3 cycle count 2", 8'h20, 32'd13);
        rd_check("R8 ev1 strobe low", 8'h24, 32'd10);
        rd_check("R8 ev2 count", 8'h28, 32'd3);
    endtask

    task automatic t_cyc_clear;
        wr(8'h00, 32'h2);
        rd_check("R6 unarmed no clear", 8'h20, 32'd13);
        wr(8'h00, 32'h0);
        rd_check("R6 armed reads clr 0", 8'h00, 32'h0);
        rd_check("R6 arm alone keeps count", 8'h20, 32'd13);
        wr(8'h00, 32'h2);
        rd_check("R6 clear done", 8'h20, 32'd0);
        rd_check("R6 idle reads clr 1", 8'h00, 32'h2);
    endtask

    task automatic t_ev_clear;
        wr(8'h04, 32'h04000004);
        rd_check("R9 ev1 cleared", 8'h24, 32'd0);
        rd_check("R9 ev clr bit reads 1", 8'h04, 32'h04000006);
        wr(8'h08, 32'h05000007);
        rd_check("R2 ovf write ignored", 8'h08, 32'h05000006);
        rd_check("R9 clr 1 keeps ev2", 8'h28, 32'd3);
    endtask

    task automatic t_cyc_wrap;
        evt_strobe = '0;
        run_cycles(255);
        rd_check("R3 cycle at max", 8'h20, 32'd255);
        check("R4 no irq before wrap", 32'(irq), 32'h0);
        run_cycles(1);
        rd_check("R4 cycle wrapped", 8'h20, 32'd0);
        check("R4 irq on wrap", 32'(irq), 32'h1);
        rd_check("R4 cycle ovf flag", 8'h00, 32'h3);
        evt_strobe = '1;
        wr(8'h00, 32'h6);
        repeat (5) @(negedge clk);
        rd_check("R4 frozen cycle", 8'h20, 32'd0);
        rd_check("R4 frozen ev1", 8'h24, 32'd0);
        rd_check("R4 frozen ev2", 8'h28, 32'd3);
        check("R5 irq held", 32'(irq), 32'h1);
        wr(8'h00, 32'h4);
        check("R5 irq held when armed", 32'(irq), 32'h1);
        wr(8'h00, 32'h6);
        check("R5 irq dropped by clear", 32'(irq), 32'h0);
        wr(8'h00, 32'h2);
        rd_check("R5 cycle resumes", 8'h20, 32'd1);
        rd_check("R8 ev1 resumes", 8'h24, 32'd1);
        rd_check("R8 ev2 resumes", 8'h28, 32'd4);
        rd_check("R8 ev3 still 0", 8'h2C, 32'd0);
    endtask

    task automatic t_ev_wrap;
        wr(8'h04, 32'h04000004);
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h2);
        evt_strobe = 64'h10;
        run_cycles(200);
        rd_check("R8 ev1 200", 8'h24, 32'd200);
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h2);
        run_cycles(56);
        rd_check("R10 ev1 wrapped", 8'h24, 32'd0);
        rd_check("R10 ev1 ovf flag", 8'h04, 32'h04000007);
        check("R10 no irq", 32'(irq), 32'h0);
        rd_check("R10 cycle unaffected", 8'h20, 32'd56);
        run_cycles(10);
        rd_check("R10 ev1 stays held", 8'h24, 32'd0);
        rd_check("R3 cycle keeps running", 8'h20, 32'd66);
        wr(8'h04, 32'h04000004);
        rd_check("R9 ovf cleared", 8'h04, 32'h04000006);
        run_cycles(2);
        rd_check("R9 ev1 counts again", 8'h24, 32'd2);
        rd_check("R8 ev2 strobe low", 8'h28, 32'd4);
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_cyc_clear();
        t_ev_clear();
        t_cyc_wrap();
        t_ev_wrap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule